// File: doc/BRIEF.md
# Serial EEPROM configuration preloader

This block fills a 32-entry shadow of 16-bit half-words that backs a bus-interface configuration space. Once reset is released, it reads a 64x16 three-wire serial EEPROM one word per frame. Each word arrives on the serial data line most significant bit first, and the block presents it on a one-cycle write port into the shadow together with a 5-bit slot index. The slots are fetched in ascending order. Each slot's EEPROM word address has its lowest bit inverted, so every even/odd pair of half-words is swapped between the EEPROM image and the shadow.

Firmware can also reload part of the shadow without the EEPROM. It places four 32-bit words on the data input, then raises the load bit and the software-reset bit together. When it drops the software-reset bit, the block copies the eight half-words into the shadow. That copy never starts fewer than a minimum number of clocks after the set. A clear that comes too early is held back until that time has passed. A busy flag covers both load paths. The configuration-access gate opens only when firmware has raised its ready bit, the EEPROM load has finished and no load is in progress.

Top module: `cfg_preload`

## Requirements
- R1: While reset is held, `busy` is 1, and `shadow_we`, `ee_cs` and `cfg_access_ok` are 0.
- R2: Each EEPROM frame raises `ee_cs` for 26 rising edges of `ee_sk`. `ee_di` carries 1, 1, 0 and then the 6-bit word address MSB first, sampled on the first nine rising edges. `ee_di` never changes on a rising edge of `ee_sk`.
- R3: Slot n (0 to 31) is read from word address n XOR 1, which is byte address 2n + 2 - 4(n mod 2) divided by two. Slots are read and written in ascending order.
- R4: The EEPROM drives a dummy bit at rising edge 10 and data bits 15 down to 0 at rising edges 11 to 26. Each of these bits is sampled at the end of the high phase of the same serial clock. The written half-word equals the EEPROM word.
- R5: `ee_sk` stays low while `ee_cs` is low. Between frames, `ee_cs` stays low for at least one full serial clock period (2*SK_HALF clocks).
- R6: Exactly one `shadow_we` pulse is issued per completed EEPROM frame, 32 in total. No write is issued without a completed frame.
- R7: `busy` stays 1 from reset release through the EEPROM load. It falls in the same cycle that the 32nd write is presented.
- R8: `cfg_access_ok` is 1 only when `cfg_ready_set` is 1, the EEPROM load has finished and `busy` is 0. Raising `cfg_ready_set` earlier has no effect on the output.
- R9: After the EEPROM load, suppose `sw_load_bit` and `sw_rst_bit` are sampled high together (the set edge), and `sw_rst_bit` is later sampled low at least SRST_MIN clocks after the set. The copy then starts on that edge. Half-word h of `sw_cfg_data` (bits 16h+15..16h) is written to slot SW_BASE+h, one per clock for h = 0 to 7, beginning the clock after the start. `busy` is 1 from the start until it falls with the last copy write.
- R10: If `sw_rst_bit` is sampled low sooner than SRST_MIN clocks after the set, the copy starts on the edge exactly SRST_MIN clocks after the set.
- R11: A software reset without the load bit starts no copy. A software request made while the EEPROM load is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to EEPROM |
| ee_do | input | 1 | Serial data from EEPROM |
| sw_cfg_data | input | 128 | Four 32-bit software configuration words |
| sw_load_bit | input | 1 | Software load-configuration request |
| sw_rst_bit | input | 1 | Software reset bit |
| cfg_ready_set | input | 1 | Firmware target-configuration-ready bit |
| shadow_we | output | 1 | Shadow write strobe |
| shadow_slot | output | 5 | Shadow half-word slot index |
| shadow_wdata | output | 16 | Shadow write data |
| busy | output | 1 | A load is in progress |
| cfg_access_ok | output | 1 | Configuration access permitted |

## Verification
An EEPROM half-word reaches the write port one clock after the falling serial-clock edge that ends its frame. The bench therefore checks writes against a queue of frames that its own EEPROM model has already finished, and checks `busy` on every cycle against the count of writes seen so far. A software copy produces its first write one clock after the start edge defined in R9 or R10. `busy` changes on that start edge and falls together with the eighth write. `cfg_access_ok` responds within the same cycle as its inputs. A behavioural model advances at each rising edge, and all outputs are compared with it at the following falling edge, well away from the edge where they change.

// File: rtl/cfgpre_pkg.sv
package cfgpre_pkg;

    localparam int HW_W      = 16;
    localparam int EE_AW     = 6;
    localparam int NUM_SLOTS = 32;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef logic [HW_W-1:0] hword_t;

    typedef struct packed {
        logic              vld;
        logic [SLOT_W-1:0] slot;
        hword_t            data;
    } shadow_wr_t;

    typedef enum logic [1:0] {
        M_EE_ISSUE,
        M_EE_WAIT,
        M_IDLE,
        M_COPY
    } seq_mode_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_XFER,
        RD_GAP
    } rd_state_e;

    // Pair swap: slot n lives at word (n + 1 - 2*(n mod 2)), i.e. n with bit 0 flipped.
    function automatic logic [EE_AW-1:0] ee_word_of_slot(input logic [SLOT_W-1:0] n);
        return EE_AW'(n) ^ EE_AW'(1);
    endfunction

endpackage

// File: rtl/cfgpre_mw_reader.sv
module cfgpre_mw_reader
    import cfgpre_pkg::*;
#(
    parameter int SK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [EE_AW-1:0] addr,
    output logic             ready,
    output logic             done,
    output hword_t           data,
    output logic             cs,
    output logic             sk,
    output logic             di,
    input  logic             do_in
);
    localparam int HDR   = 3 + EE_AW;
    localparam int BITS  = HDR + 1 + HW_W;
    localparam int BIT_W = $clog2(BITS);
    localparam int PH_W  = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;
    localparam logic [BIT_W-1:0] FIRST_DATA = BIT_W'(HDR + 1);
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(BITS - 1);
    localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(SK_HALF - 1);

    rd_state_e        st;
    logic [PH_W-1:0]  ph;
    logic             hi;
    logic [BIT_W-1:0] bit_i;
    logic [HDR-2:0]   hdr_q;
    hword_t           sh;

    assign ready = (st == RD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RD_IDLE;
            ph    <= '0;
            hi    <= 1'b0;
            bit_i <= '0;
            hdr_q <= '0;
            sh    <= '0;
            data  <= '0;
            done  <= 1'b0;
            cs    <= 1'b0;
            sk    <= 1'b0;
            di    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                RD_IDLE: begin
                    if (start) begin
                        st    <= RD_XFER;
                        cs    <= 1'b1;
                        sk    <= 1'b0;
                        di    <= 1'b1;
                        hdr_q <= {2'b10, addr};
                        bit_i <= '0;
                        ph    <= '0;
                        hi    <= 1'b0;
                    end
                end
                RD_XFER: begin
                    if (ph == PH_LAST) begin
                        ph <= '0;
                        if (!hi) begin
                            hi <= 1'b1;
                            sk <= 1'b1;
                        end else begin
                            hi <= 1'b0;
                            sk <= 1'b0;
                            if (bit_i >= FIRST_DATA) sh <= {sh[HW_W-2:0], do_in};
                            if (bit_i == LAST_BIT) begin
                                st   <= RD_GAP;
                                cs   <= 1'b0;
                                di   <= 1'b0;
                                done <= 1'b1;
                                data <= {sh[HW_W-2:0], do_in};
                            end else begin
                                bit_i <= bit_i + 1'b1;
                                di    <= hdr_q[HDR-2];
                                hdr_q <= hdr_q << 1;
                            end
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                RD_GAP: begin
                    if (ph == PH_LAST) begin
                        ph <= '0;
                        hi <= ~hi;
                        if (hi) st <= RD_IDLE;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgpre_srst_gate.sv
module cfgpre_srst_gate #(
    parameter int MIN_HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_ok,
    input  logic srst,
    input  logic load_req,
    output logic go
);
    localparam int CW = $clog2(MIN_HOLD + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(MIN_HOLD);

    logic          armed;
    logic [CW-1:0] cnt;

    assign go = armed && !srst && (cnt == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (go) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed) begin
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
        end else if (arm_ok && srst && load_req) begin
            armed <= 1'b1;
            cnt   <= CW'(1);
        end
    end
endmodule

// File: rtl/cfg_preload.sv
module cfg_preload
    import cfgpre_pkg::*;
#(
    parameter int SK_HALF  = 2,
    parameter int SRST_MIN = 4,
    parameter int SW_WORDS = 4,
    parameter int SW_BASE  = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   ee_cs,
    output logic                   ee_sk,
    output logic                   ee_di,
    input  logic                   ee_do,
    input  logic [SW_WORDS*32-1:0] sw_cfg_data,
    input  logic                   sw_load_bit,
    input  logic                   sw_rst_bit,
    input  logic                   cfg_ready_set,
    output logic                   shadow_we,
    output logic [SLOT_W-1:0]      shadow_slot,
    output logic [HW_W-1:0]        shadow_wdata,
    output logic                   busy,
    output logic                   cfg_access_ok
);
    localparam int SW_HW = 2 * SW_WORDS;
    localparam int CI_W  = (SW_HW > 1) ? $clog2(SW_HW) : 1;
    localparam logic [CI_W-1:0]   CI_LAST   = CI_W'(SW_HW - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    seq_mode_e         mode;
    logic [SLOT_W-1:0] slot_q;
    logic [CI_W-1:0]   copy_idx;
    logic              busy_q;
    logic              loaded_q;
    shadow_wr_t        wr_q;

    logic   rd_start, rd_ready, rd_done, sw_go;
    hword_t rd_data;
    hword_t sw_half [SW_HW];

    for (genvar g = 0; g < SW_HW; g++) begin : g_half
        assign sw_half[g] = sw_cfg_data[g*HW_W +: HW_W];
    end

    assign rd_start = (mode == M_EE_ISSUE) && rd_ready;

    cfgpre_mw_reader #(.SK_HALF(SK_HALF)) u_reader (
        .clk   (clk),
        .rst   (rst),
        .start (rd_start),
        .addr  (ee_word_of_slot(slot_q)),
        .ready (rd_ready),
        .done  (rd_done),
        .data  (rd_data),
        .cs    (ee_cs),
        .sk    (ee_sk),
        .di    (ee_di),
        .do_in (ee_do)
    );

    cfgpre_srst_gate #(.MIN_HOLD(SRST_MIN)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .arm_ok   ((mode == M_IDLE) && loaded_q),
        .srst     (sw_rst_bit),
        .load_req (sw_load_bit),
        .go       (sw_go)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= M_EE_ISSUE;
            slot_q   <= '0;
            copy_idx <= '0;
            busy_q   <= 1'b1;
            loaded_q <= 1'b0;
            wr_q     <= '0;
        end else begin
            wr_q.vld <= 1'b0;
            case (mode)
                M_EE_ISSUE: if (rd_ready) mode <= M_EE_WAIT;
                M_EE_WAIT: begin
                    if (rd_done) begin
                        wr_q <= '{vld: 1'b1, slot: slot_q, data: rd_data};
                        if (slot_q == SLOT_LAST) begin
                            busy_q   <= 1'b0;
                            loaded_q <= 1'b1;
                            mode     <= M_IDLE;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                            mode   <= M_EE_ISSUE;
                        end
                    end
                end
                M_IDLE: begin
                    if (sw_go) begin
                        mode     <= M_COPY;
                        busy_q   <= 1'b1;
                        copy_idx <= '0;
                    end
                end
                M_COPY: begin
                    wr_q <= '{vld: 1'b1,
                              slot: SLOT_W'(SW_BASE) + SLOT_W'(copy_idx),
                              data: sw_half[copy_idx]};
                    if (copy_idx == CI_LAST) begin
                        mode   <= M_IDLE;
                        busy_q <= 1'b0;
                    end else begin
                        copy_idx <= copy_idx + 1'b1;
                    end
                end
                default: mode <= M_IDLE;
            endcase
        end
    end

    assign shadow_we     = wr_q.vld;
    assign shadow_slot   = wr_q.slot;
    assign shadow_wdata  = wr_q.data;
    assign busy          = busy_q;
    assign cfg_access_ok = cfg_ready_set && loaded_q && !busy_q;
endmodule

// File: rtl/cfg_preload_chk.sv
module cfg_preload_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic shadow_we,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di,
    input logic cfg_access_ok
);
    // R2: serial clock rises only inside a frame
    a_r2_sk_inside_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_sk) |-> ee_cs);

    // R2: data to the EEPROM is steady across each rising serial edge
    a_r2_di_steady_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_sk) |-> $stable(ee_di));

    // R5: serial clock idles low outside a frame
    a_r5_sk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_sk);

    // R6: every write is issued while a load was in progress
    a_r6_write_under_busy: assert property (@(posedge clk) disable iff (rst)
        shadow_we |-> $past(busy));

    // R7: busy only drops together with the final write of a load
    a_r7_busy_drops_with_write: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> shadow_we);

    // R8: the access gate never opens during a load
    a_r8_gate_closed_when_busy: assert property (@(posedge clk) disable iff (rst)
        cfg_access_ok |-> !busy);
endmodule

bind cfg_preload cfg_preload_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .shadow_we     (shadow_we),
    .ee_cs         (ee_cs),
    .ee_sk         (ee_sk),
    .ee_di         (ee_di),
    .cfg_access_ok (cfg_access_ok)
);

// File: tb/cfg_preload_bench.sv
`timescale 1ns/1ps
module cfg_preload_bench;
    localparam int SKH = 2;
    localparam int SRM = 4;
    localparam int SWW = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ee_cs, ee_sk, ee_di;
    logic           ee_do = 1'b0;
    logic [127:0]   sw_cfg_data = '0;
    logic           sw_load_bit = 1'b0;
    logic           sw_rst_bit = 1'b0;
    logic           cfg_ready_set = 1'b0;
    logic           shadow_we;
    logic [4:0]     shadow_slot;
    logic [15:0]    shadow_wdata;
    logic           busy, cfg_access_ok;

    always #4 clk = ~clk;

    cfg_preload #(.SK_HALF(SKH), .SRST_MIN(SRM), .SW_WORDS(SWW), .SW_BASE(0)) u_cfg_preload (
        .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .sw_cfg_data(sw_cfg_data), .sw_load_bit(sw_load_bit), .sw_rst_bit(sw_rst_bit),
        .cfg_ready_set(cfg_ready_set), .shadow_we(shadow_we), .shadow_slot(shadow_slot),
        .shadow_wdata(shadow_wdata), .busy(busy), .cfg_access_ok(cfg_access_ok)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    phase   = 0;
    int    cyc     = 0;
    bit    finished = 0;
    string cur_req = "R9";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] rom(input int a);
        return 16'((a * 40503 + 4660) ^ (a << 11));
    endfunction

    // EEPROM model and reference state
    int          k = 0;
    logic [8:0]  rx = '0;
    logic [5:0]  cur_a = '0;
    logic [15:0] word_v;
    int          frame_no = 0;
    int          q_slot[$];
    logic [15:0] q_data[$];
    int          ee_writes = 0;
    int          sw_writes = 0;
    int          low_run = 0;
    logic        prev_sk = 1'b0;
    logic        prev_cs = 1'b0;

    // software-path behavioural model, advanced at each rising edge
    bit          m_wr = 0;
    int          m_slot = 0;
    logic [15:0] m_data = '0;
    bit          m_busy = 0;
    bit          m_armed = 0;
    int          m_since = 0;
    int          m_pos = -1;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R6: run did not complete, actual %0d expected %0d", cyc, 100000);
            wrap_up();
        end
        if (phase == 2) begin
            m_wr = 0;
            if (m_armed) m_since++;
            if (m_pos >= 0) begin
                m_wr   = 1;
                m_slot = m_pos;
                m_data = sw_cfg_data[16*m_pos +: 16];
                if (m_pos == 2*SWW-1) begin
                    m_pos  = -1;
                    m_busy = 0;
                end else m_pos++;
            end else if (m_armed && !sw_rst_bit && m_since >= SRM) begin
                m_armed = 0;
                m_busy  = 1;
                m_pos   = 0;
            end else if (!m_armed && sw_rst_bit && sw_load_bit) begin
                m_armed = 1;
                m_since = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (ee_sk && !prev_sk) begin
                chk(ee_cs, "R2", "serial clock rose without chip select", ee_cs, 1);
                if (k < 9) begin
                    rx = {rx[7:0], ee_di};
                    if (k == 8) begin
                        cur_a = rx[5:0];
                        chk(rx[8:6] == 3'b110, "R2", "start bit and read opcode", rx[8:6], 3'b110);
                        chk(cur_a == 6'(frame_no ^ 1), "R3", "word address for slot", cur_a, frame_no ^ 1);
                    end
                end
                word_v = rom(int'(cur_a));
                if (k == 9) ee_do = 1'b0;
                else if (k >= 10) ee_do = word_v[25-k];
                if (k == 25) begin
                    q_slot.push_back(frame_no);
                    q_data.push_back(word_v);
                    frame_no++;
                    k = 0;
                end else k++;
            end
            if (ee_cs && !prev_cs && frame_no > 0)
                chk(low_run >= 2*SKH, "R5", "chip select gap between frames", low_run, 2*SKH);
            if (!ee_cs) low_run++;
            else low_run = 0;
            prev_sk = ee_sk;
            prev_cs = ee_cs;

            if (phase == 1) begin
                if (shadow_we) begin
                    if (q_slot.size() == 0) begin
                        chk(0, "R6", "write without a completed frame", shadow_slot, 0);
                    end else begin
                        int          es;
                        logic [15:0] ed;
                        es = q_slot.pop_front();
                        ed = q_data.pop_front();
                        chk(shadow_slot == 5'(es), "R3", "slot order", shadow_slot, es);
                        chk(shadow_wdata == ed, "R4", "half-word data", shadow_wdata, ed);
                    end
                    ee_writes++;
                end
                chk(busy == (ee_writes < 32), "R7", "busy during EEPROM load", busy, ee_writes < 32);
                chk(cfg_access_ok == (cfg_ready_set && ee_writes >= 32), "R8",
                    "access gate during EEPROM load", cfg_access_ok, cfg_ready_set && ee_writes >= 32);
            end else if (phase == 2) begin
                chk(shadow_we == m_wr, cur_req, "copy write strobe", shadow_we, m_wr);
                if (m_wr && shadow_we) begin
                    chk(shadow_slot == 5'(m_slot), cur_req, "copy slot", shadow_slot, m_slot);
                    chk(shadow_wdata == m_data, cur_req, "copy data", shadow_wdata, m_data);
                end
                chk(busy == m_busy, cur_req, "busy during copy", busy, m_busy);
                chk(cfg_access_ok == (cfg_ready_set && !m_busy), "R8", "access gate after load",
                    cfg_access_ok, cfg_ready_set && !m_busy);
                chk(!ee_cs, "R6", "no EEPROM frame after load", ee_cs, 0);
                if (shadow_we) sw_writes++;
            end
        end
    end

    initial begin
        cfg_ready_set = 1'b1;
        repeat (3) step();
        // R1: state while reset is held
        chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
        chk(shadow_we == 1'b0, "R1", "write strobe in reset", shadow_we, 0);
        chk(ee_cs == 1'b0, "R1", "chip select in reset", ee_cs, 0);
        chk(cfg_access_ok == 1'b0, "R1", "access gate in reset", cfg_access_ok, 0);
        rst = 1'b0;
        phase = 1;
        repeat (50) step();
        // R11: software request during the EEPROM load must be ignored
        sw_cfg_data = {8{16'hDEAD}};
        sw_load_bit = 1'b1;
        sw_rst_bit  = 1'b1;
        repeat (6) step();
        sw_load_bit = 1'b0;
        sw_rst_bit  = 1'b0;
        wait (ee_writes == 32);
        step();
        chk(frame_no == 32, "R6", "frames read", frame_no, 32);
        chk(q_slot.size() == 0, "R6", "frames left without a write", q_slot.size(), 0);
        chk(cfg_access_ok == 1'b1, "R8", "gate open after load", cfg_access_ok, 1);
        phase = 2;

        // R9: normal software load with the reset bit held long enough
        cur_req = "R9";
        sw_cfg_data = {16'h7007, 16'h6006, 16'h5005, 16'h4004,
                       16'h3003, 16'h2002, 16'h1001, 16'h0A00};
        sw_load_bit = 1'b1;
        sw_rst_bit  = 1'b1;
        repeat (6) step();
        sw_rst_bit  = 1'b0;
        sw_load_bit = 1'b0;
        repeat (14) step();

        // R10: reset bit cleared too early, copy held back
        cur_req = "R10";
        sw_cfg_data = {16'hF0E1, 16'hD2C3, 16'hB4A5, 16'h9687,
                       16'h7869, 16'h5A4B, 16'h3C2D, 16'h1E0F};
        sw_load_bit = 1'b1;
        sw_rst_bit  = 1'b1;
        step();
        sw_rst_bit  = 1'b0;
        sw_load_bit = 1'b0;
        repeat (14) step();

        // R11: software reset without the load bit
        cur_req = "R11";
        sw_rst_bit = 1'b1;
        repeat (6) step();
        sw_rst_bit = 1'b0;
        repeat (12) step();
        chk(sw_writes == 16, "R9", "total copy writes", sw_writes, 16);

        cfg_ready_set = 1'b0;
        repeat (2) step();
        chk(cfg_access_ok == 1'b0, "R8", "gate closed when ready bit low", cfg_access_ok, 0);
        wrap_up();
    end
endmodule